// File: doc/BRIEF.md
# Single-Hart Retire-Paced Timer Interrupt Unit

This block gives one processor hart a memory-mapped timer and a software doorbell. It keeps a 64-bit time count, a 64-bit alarm threshold and a one-bit software-interrupt flag. It drives two level-sensitive interrupt lines to the core. The timer line stays high while the time count is at or above the threshold. The software line shows the flag.

The time count does not follow a wall clock. It advances by one after every `RETIRE_PER_TICK` pulses on the instruction-retire input. Software reads and writes the three registers through a small register port: offset, size code, read and write strobes, and write data. Each accepted strobe gets a response one cycle later. The response carries read data or an error flag.

The response path is a small state machine with three states. `ST_IDLE` means no response is pending. `ST_ACK` means a legal access completed. `ST_FAULT` means the access was rejected. On every clock edge the machine takes one of three transitions. `GO_FAULT` is taken for a rejected strobe, `GO_ACK` for a legal strobe, and `GO_IDLE` when no strobe is present. Any state can reach any other state in one cycle, so back-to-back accesses work.

Top module: `hart_tick_irq`

## Requirements
- R1: After reset the time count, the threshold and the software flag are all zero, and the retire prescaler restarts from zero. As a result `timer_irq_o`=1, `sw_irq_o`=0, `acc_vld_o`=0 and `acc_rdata_o`=0.
- R2: The time count increases by exactly one on every `RETIRE_PER_TICK`-th retire pulse counted since reset. Cycles with `retire_i` low do not count. The count wraps from the low half into the high half as a normal 64-bit increment.
- R3: Every cycle with `acc_rd_i` or `acc_wr_i` high produces `acc_vld_o`=1 in the following cycle, and only such cycles do.
- R4: Size code 2 means a 4-byte access and size code 3 means an 8-byte access. These are the only legal (offset, size) pairs:
  - offset 0x0000 with size 2 or 3: the software flag
  - offset 0x4000 with size 3: the whole threshold
  - offset 0x4000 with size 2: the low half of the threshold
  - offset 0x4004 with size 2: the high half of the threshold
  - offset 0xBFF8 with size 3: the whole time count
  - offset 0xBFF8 with size 2: the low half of the time count
  - offset 0xBFFC with size 2: the high half of the time count
- R5: A strobe with any other (offset, size) pair, or with read and write both high, gets `acc_err_o`=1 with `acc_vld_o`=1 and `acc_rdata_o`=0. It changes no register.
- R6: An 8-byte read returns all 64 bits. A 4-byte read returns the selected half in bits 31:0, with bits 63:32 zero. The value returned is the register content in the cycle the strobe is sampled. Writes and rejected accesses respond with zero data.
- R7: The software flag stores only write-data bit 0. A read of the flag returns it in bit 0, with all other bits zero. `sw_irq_o` equals the stored flag.
- R8: A 4-byte threshold write replaces one half with write-data bits 31:0. An 8-byte threshold write replaces the whole threshold.
- R9: Time-count writes follow the same half rules as R8. If a write and a prescaler tick fall in the same cycle, the write wins and that tick is lost. The prescaler keeps counting through the write.
- R10: `timer_irq_o` is high exactly when the time count is greater than or equal to the threshold, compared as unsigned numbers. It follows any register change in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| retire_i | input | 1 | One pulse per retired instruction |
| acc_addr_i | input | 16 | Register offset |
| acc_size_i | input | 2 | Access size code (2 = 4 bytes, 3 = 8 bytes) |
| acc_rd_i | input | 1 | Read strobe |
| acc_wr_i | input | 1 | Write strobe |
| acc_wdata_i | input | 64 | Write data |
| acc_rdata_o | output | 64 | Read data, valid with `acc_vld_o` |
| acc_vld_o | output | 1 | Response for the previous cycle's strobe |
| acc_err_o | output | 1 | The response is a rejection |
| timer_irq_o | output | 1 | Timer interrupt level |
| sw_irq_o | output | 1 | Software interrupt level |

## Verification
Several retire patterns are applied, each testing a different part of the prescaler:
- isolated pulses with idle gaps, which show that idle cycles are not counted;
- long unbroken runs, which show that exactly every Nth pulse ticks;
- pulses that coincide with time writes, which show that the write wins over the tick.

The threshold is tested with three kinds of values. Small thresholds separate greater-or-equal from strictly-greater. A threshold with only the top bit set separates unsigned comparison from signed comparison. A count just below a 32-bit boundary shows whether the carry reaches the high half.

Every rejected (offset, size) pair is followed by reads. These reads separate a correct decode, which leaves state unchanged, from one that lets a rejected write through.

A long mixed phase interleaves legal and illegal accesses with irregular retire traffic. It is compared against the behavioural model on every clock.

// File: rtl/htmr_pkg.sv
`timescale 1ns/1ps
package htmr_pkg;
    localparam int unsigned OFS_W = 16;
    localparam int unsigned DW    = 64;
    localparam int unsigned HW    = DW / 2;

    // register offsets
    localparam logic [OFS_W-1:0] OFS_SOFT    = 16'h0000;
    localparam logic [OFS_W-1:0] OFS_CMP_LO  = 16'h4000;
    localparam logic [OFS_W-1:0] OFS_CMP_HI  = 16'h4004;
    localparam logic [OFS_W-1:0] OFS_TIME_LO = 16'hBFF8;
    localparam logic [OFS_W-1:0] OFS_TIME_HI = 16'hBFFC;

    // size codes
    localparam logic [1:0] SZ_WORD  = 2'd2;
    localparam logic [1:0] SZ_DWORD = 2'd3;

    typedef enum logic [2:0] {
        TGT_NONE,
        TGT_SOFT,
        TGT_CMP_LO,
        TGT_CMP_HI,
        TGT_CMP_ALL,
        TGT_TIME_LO,
        TGT_TIME_HI,
        TGT_TIME_ALL
    } tgt_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ACK,
        ST_FAULT
    } rsp_state_e;
endpackage

// File: rtl/htmr_decode.sv
`timescale 1ns/1ps
module htmr_decode
    import htmr_pkg::*;
(
    input  logic [OFS_W-1:0] addr_i,
    input  logic [1:0]       size_i,
    input  logic             rd_i,
    input  logic             wr_i,
    output tgt_e             tgt_o,
    output logic             fault_o
);
    tgt_e map;
    logic req;

    always_comb begin
        map = TGT_NONE;
        if (size_i == SZ_DWORD) begin
            if (addr_i == OFS_SOFT)         map = TGT_SOFT;
            else if (addr_i == OFS_CMP_LO)  map = TGT_CMP_ALL;
            else if (addr_i == OFS_TIME_LO) map = TGT_TIME_ALL;
        end else if (size_i == SZ_WORD) begin
            if (addr_i == OFS_SOFT)         map = TGT_SOFT;
            else if (addr_i == OFS_CMP_LO)  map = TGT_CMP_LO;
            else if (addr_i == OFS_CMP_HI)  map = TGT_CMP_HI;
            else if (addr_i == OFS_TIME_LO) map = TGT_TIME_LO;
            else if (addr_i == OFS_TIME_HI) map = TGT_TIME_HI;
        end
    end

    assign req     = rd_i | wr_i;
    assign fault_o = req && ((rd_i && wr_i) || (map == TGT_NONE));
    assign tgt_o   = (req && !fault_o) ? map : TGT_NONE;
endmodule

// File: rtl/htmr_prescale.sv
`timescale 1ns/1ps
module htmr_prescale #(
    parameter int unsigned RETIRE_PER_TICK = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic retire_i,
    output logic tick_o
);
    localparam int unsigned CW = (RETIRE_PER_TICK > 1) ? $clog2(RETIRE_PER_TICK) : 1;
    localparam logic [CW-1:0] LAST = CW'(RETIRE_PER_TICK - 1);

    logic [CW-1:0] cnt_q;
    logic          at_last;

    assign at_last = (cnt_q == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (retire_i) begin
            cnt_q <= at_last ? '0 : cnt_q + CW'(1);
        end
    end

    assign tick_o = retire_i && at_last;
endmodule

// File: rtl/htmr_counters.sv
`timescale 1ns/1ps
module htmr_counters
    import htmr_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick_i,
    input  logic [1:0]    time_we_i,
    input  logic [1:0]    cmp_we_i,
    input  logic [HW-1:0] wlo_i,
    input  logic [HW-1:0] whi_i,
    output logic [DW-1:0] time_o,
    output logic [DW-1:0] cmp_o,
    output logic          alarm_o
);
    logic [DW-1:0] time_inc;
    logic          time_hold;

    assign time_inc  = time_o + DW'(1);
    assign time_hold = (time_we_i != 2'b00);

    for (genvar h = 0; h < 2; h++) begin : g_half
        logic [HW-1:0] wd;
        logic [HW-1:0] t_q;
        logic [HW-1:0] c_q;

        assign wd = (h == 0) ? wlo_i : whi_i;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                t_q <= '0;
                c_q <= '0;
            end else begin
                if (time_hold) begin
                    if (time_we_i[h]) t_q <= wd;
                end else if (tick_i) begin
                    t_q <= time_inc[h*HW +: HW];
                end
                if (cmp_we_i[h]) c_q <= wd;
            end
        end
    end

    assign time_o  = {g_half[1].t_q, g_half[0].t_q};
    assign cmp_o   = {g_half[1].c_q, g_half[0].c_q};
    assign alarm_o = (time_o >= cmp_o);
endmodule

// File: rtl/hart_tick_irq.sv
`timescale 1ns/1ps
module hart_tick_irq
    import htmr_pkg::*;
#(
    parameter int unsigned RETIRE_PER_TICK = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             retire_i,
    input  logic [OFS_W-1:0] acc_addr_i,
    input  logic [1:0]       acc_size_i,
    input  logic             acc_rd_i,
    input  logic             acc_wr_i,
    input  logic [DW-1:0]    acc_wdata_i,
    output logic [DW-1:0]    acc_rdata_o,
    output logic             acc_vld_o,
    output logic             acc_err_o,
    output logic             timer_irq_o,
    output logic             sw_irq_o
);
    tgt_e          tgt;
    logic          fault;
    logic          tick;
    rsp_state_e    st_q, st_d;
    logic          soft_q;
    logic          soft_we;
    logic [1:0]    time_we, cmp_we;
    logic [HW-1:0] wlo, whi;
    logic [DW-1:0] time_val, cmp_val;
    logic [DW-1:0] rd_val;
    logic [DW-1:0] rdata_q;
    logic          wr_ok;
    logic          rd_ok;

    htmr_decode u_dec (
        .addr_i  (acc_addr_i),
        .size_i  (acc_size_i),
        .rd_i    (acc_rd_i),
        .wr_i    (acc_wr_i),
        .tgt_o   (tgt),
        .fault_o (fault)
    );

    htmr_prescale #(.RETIRE_PER_TICK(RETIRE_PER_TICK)) u_pre (
        .clk      (clk),
        .rst_n    (rst_n),
        .retire_i (retire_i),
        .tick_o   (tick)
    );

    htmr_counters u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_i    (tick),
        .time_we_i (time_we),
        .cmp_we_i  (cmp_we),
        .wlo_i     (wlo),
        .whi_i     (whi),
        .time_o    (time_val),
        .cmp_o     (cmp_val),
        .alarm_o   (timer_irq_o)
    );

    assign wr_ok = acc_wr_i && (tgt != TGT_NONE);
    assign rd_ok = acc_rd_i && (tgt != TGT_NONE);

    // next state: GO_FAULT, GO_ACK, GO_IDLE
    always_comb begin
        st_d = ST_IDLE;
        unique case (st_q)
            ST_IDLE, ST_ACK, ST_FAULT: begin
                if (fault)                 st_d = ST_FAULT;
                else if (tgt != TGT_NONE)  st_d = ST_ACK;
                else                       st_d = ST_IDLE;
            end
            default: st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    always_comb begin
        acc_vld_o = 1'b0;
        acc_err_o = 1'b0;
        unique case (st_q)
            ST_IDLE:  ;
            ST_ACK:   acc_vld_o = 1'b1;
            ST_FAULT: begin
                acc_vld_o = 1'b1;
                acc_err_o = 1'b1;
            end
            default:  ;
        endcase
    end

    // write steering
    always_comb begin
        soft_we = 1'b0;
        time_we = 2'b00;
        cmp_we  = 2'b00;
        wlo     = acc_wdata_i[HW-1:0];
        whi     = acc_wdata_i[HW-1:0];
        if (wr_ok) begin
            case (tgt)
                TGT_SOFT:     soft_we = 1'b1;
                TGT_CMP_LO:   cmp_we  = 2'b01;
                TGT_CMP_HI:   cmp_we  = 2'b10;
                TGT_CMP_ALL: begin
                    cmp_we = 2'b11;
                    whi    = acc_wdata_i[DW-1:HW];
                end
                TGT_TIME_LO:  time_we = 2'b01;
                TGT_TIME_HI:  time_we = 2'b10;
                TGT_TIME_ALL: begin
                    time_we = 2'b11;
                    whi     = acc_wdata_i[DW-1:HW];
                end
                default: ;
            endcase
        end
    end

    // read selection
    always_comb begin
        rd_val = '0;
        case (tgt)
            TGT_SOFT:     rd_val = {{(DW-1){1'b0}}, soft_q};
            TGT_CMP_LO:   rd_val = {{HW{1'b0}}, cmp_val[HW-1:0]};
            TGT_CMP_HI:   rd_val = {{HW{1'b0}}, cmp_val[DW-1:HW]};
            TGT_CMP_ALL:  rd_val = cmp_val;
            TGT_TIME_LO:  rd_val = {{HW{1'b0}}, time_val[HW-1:0]};
            TGT_TIME_HI:  rd_val = {{HW{1'b0}}, time_val[DW-1:HW]};
            TGT_TIME_ALL: rd_val = time_val;
            default:      rd_val = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            soft_q  <= 1'b0;
            rdata_q <= '0;
        end else begin
            if (soft_we) soft_q <= acc_wdata_i[0];
            rdata_q <= rd_ok ? rd_val : '0;
        end
    end

    assign acc_rdata_o = rdata_q;
    assign sw_irq_o    = soft_q;
endmodule

// File: rtl/htmr_checker.sv
`timescale 1ns/1ps
module htmr_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        retire_i,
    input logic        acc_rd_i,
    input logic        acc_wr_i,
    input logic [63:0] acc_rdata_o,
    input logic        acc_vld_o,
    input logic        acc_err_o,
    input logic        timer_irq_o,
    input logic        sw_irq_o,
    input logic [63:0] time_val,
    input logic [63:0] cmp_val
);
    // R3: a strobe gets a response in the next cycle
    a_r3_resp_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_rd_i || acc_wr_i) |=> acc_vld_o);

    // R3: no response without a strobe
    a_r3_no_spurious_resp: assert property (@(posedge clk) disable iff (!rst_n)
        !(acc_rd_i || acc_wr_i) |=> !acc_vld_o);

    // R5: a rejection leaves the threshold and the flag as they were
    a_r5_err_keeps_state: assert property (@(posedge clk) disable iff (!rst_n)
        acc_err_o |-> ($stable(cmp_val) && $stable(sw_irq_o)));

    // R5: a rejection carries zero data
    a_r5_err_zero_data: assert property (@(posedge clk) disable iff (!rst_n)
        acc_err_o |-> (acc_rdata_o == 64'd0));

    // R2: without a write the count moves by at most one
    a_r2_step_at_most_one: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_wr_i |=> ((time_val == $past(time_val)) || (time_val == $past(time_val) + 64'd1)));

    // R2: no retire and no write keeps the count
    a_r2_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!retire_i && !acc_wr_i) |=> $stable(time_val));

    // R7: the flag changes only after a write
    a_r7_flag_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_wr_i |=> $stable(sw_irq_o));

    // R10: the timer line rises only when the count or threshold moved
    a_r10_rise_needs_change: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(timer_irq_o) |-> (!$stable(time_val) || !$stable(cmp_val)));
endmodule

bind hart_tick_irq htmr_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .retire_i    (retire_i),
    .acc_rd_i    (acc_rd_i),
    .acc_wr_i    (acc_wr_i),
    .acc_rdata_o (acc_rdata_o),
    .acc_vld_o   (acc_vld_o),
    .acc_err_o   (acc_err_o),
    .timer_irq_o (timer_irq_o),
    .sw_irq_o    (sw_irq_o),
    .time_val    (time_val),
    .cmp_val     (cmp_val)
);

// File: tb/test_hart_tick_irq.sv
`timescale 1ns/1ps
module test_hart_tick_irq;
    localparam int N = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        retire = 1'b0;
    logic [15:0] acc_addr = '0;
    logic [1:0]  acc_size = '0;
    logic        acc_rd = 1'b0;
    logic        acc_wr = 1'b0;
    logic [63:0] acc_wdata = '0;
    logic [63:0] acc_rdata;
    logic        acc_vld, acc_err, timer_irq, sw_irq;

    int checks = 0;
    int failures = 0;
    string cur_tag = "R1";

    always #10 clk = ~clk;

    hart_tick_irq #(.RETIRE_PER_TICK(N)) i_hart_tick_irq (
        .clk         (clk),
        .rst_n       (rst_n),
        .retire_i    (retire),
        .acc_addr_i  (acc_addr),
        .acc_size_i  (acc_size),
        .acc_rd_i    (acc_rd),
        .acc_wr_i    (acc_wr),
        .acc_wdata_i (acc_wdata),
        .acc_rdata_o (acc_rdata),
        .acc_vld_o   (acc_vld),
        .acc_err_o   (acc_err),
        .timer_irq_o (timer_irq),
        .sw_irq_o    (sw_irq)
    );

    // ---------------- reference model ----------------
    logic [63:0] m_time = '0, m_cmp = '0, m_rdata = '0;
    logic        m_soft = 1'b0, m_vld = 1'b0, m_err = 1'b0;
    logic        m_tick, m_twr;
    int          m_pre = 0;

    function automatic bit m_legal(logic [15:0] a, logic [1:0] s);
        if (s == 2'd3) return (a == 16'h0000) || (a == 16'h4000) || (a == 16'hBFF8);
        if (s == 2'd2) return a inside {16'h0000, 16'h4000, 16'h4004, 16'hBFF8, 16'hBFFC};
        return 1'b0;
    endfunction

    function automatic logic [63:0] m_read(logic [15:0] a, logic [1:0] s);
        if (a == 16'h0000) return {63'd0, m_soft};
        if (a == 16'h4000) return (s == 2'd3) ? m_cmp : {32'd0, m_cmp[31:0]};
        if (a == 16'h4004) return {32'd0, m_cmp[63:32]};
        if (a == 16'hBFF8) return (s == 2'd3) ? m_time : {32'd0, m_time[31:0]};
        return {32'd0, m_time[63:32]};
    endfunction

    function automatic void m_write(logic [15:0] a, logic [1:0] s, logic [63:0] d);
        if (a == 16'h0000) m_soft = d[0];
        else if (a == 16'h4000) begin
            if (s == 2'd3) m_cmp = d; else m_cmp[31:0] = d[31:0];
        end else if (a == 16'h4004) m_cmp[63:32] = d[31:0];
        else if (a == 16'hBFF8) begin
            if (s == 2'd3) m_time = d; else m_time[31:0] = d[31:0];
            m_twr = 1'b1;
        end else begin
            m_time[63:32] = d[31:0];
            m_twr = 1'b1;
        end
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_time = '0; m_cmp = '0; m_soft = 1'b0; m_pre = 0;
            m_vld = 1'b0; m_err = 1'b0; m_rdata = '0;
        end else begin
            m_tick = retire && (m_pre == N - 1);
            if (retire) m_pre = (m_pre == N - 1) ? 0 : m_pre + 1;
            m_twr = 1'b0;
            m_vld = acc_rd | acc_wr;
            m_err = 1'b0;
            m_rdata = '0;
            if (m_vld) begin
                if ((acc_rd && acc_wr) || !m_legal(acc_addr, acc_size)) m_err = 1'b1;
                else if (acc_rd) m_rdata = m_read(acc_addr, acc_size);
                else m_write(acc_addr, acc_size, acc_wdata);
            end
            if (!m_twr && m_tick) m_time = m_time + 64'd1;
        end
    end

    task automatic chk(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // compare against the model on every clock, away from the edge
    always @(posedge clk) begin
        #5;
        chk("R10", "timer_irq", {63'd0, timer_irq}, {63'd0, (m_time >= m_cmp)});
        chk("R7", "sw_irq", {63'd0, sw_irq}, {63'd0, m_soft});
        chk("R3", "acc_vld", {63'd0, acc_vld}, {63'd0, m_vld});
        chk(cur_tag, "acc_err", {63'd0, acc_err}, {63'd0, m_err});
        chk(cur_tag, "acc_rdata", acc_rdata, m_rdata);
    end

    // ---------------- stimulus ----------------
    task automatic access(input logic rd, input logic wr, input logic [15:0] a,
                          input logic [1:0] s, input logic [63:0] d, input logic ret);
        acc_rd = rd; acc_wr = wr; acc_addr = a; acc_size = s; acc_wdata = d; retire = ret;
        @(negedge clk);
        acc_rd = 1'b0; acc_wr = 1'b0; retire = 1'b0;
    endtask

    task automatic rd_expect(input string tag, input logic [15:0] a, input logic [1:0] s,
                             input logic [63:0] exp);
        access(1'b1, 1'b0, a, s, 64'd0, 1'b0);
        chk(tag, "read value", acc_rdata, exp);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL R3 watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        cur_tag = "R1";
        chk("R1", "timer_irq after reset", {63'd0, timer_irq}, 64'd1);
        chk("R1", "sw_irq after reset", {63'd0, sw_irq}, 64'd0);
        chk("R1", "acc_vld after reset", {63'd0, acc_vld}, 64'd0);
        rd_expect("R1", 16'hBFF8, 2'd3, 64'd0);
        rd_expect("R1", 16'h4000, 2'd3, 64'd0);
        rd_expect("R1", 16'h0000, 2'd2, 64'd0);

        // R2 isolated retire pulses with gaps
        cur_tag = "R2";
        for (int k = 0; k < 7; k++) begin
            retire = 1'b1; @(negedge clk);
            retire = 1'b0; @(negedge clk);
        end
        rd_expect("R2", 16'hBFF8, 2'd3, 64'd7 / N);
        rd_expect("R6", 16'hBFF8, 2'd2, 64'd7 / N);

        // R8 threshold writes
        cur_tag = "R8";
        access(1'b0, 1'b1, 16'h4000, 2'd3, 64'h0000_0001_0000_0010, 1'b0);
        rd_expect("R8", 16'h4004, 2'd2, 64'd1);
        access(1'b0, 1'b1, 16'h4004, 2'd2, 64'hFFFF_FFFF_0000_0000, 1'b0);
        rd_expect("R8", 16'h4000, 2'd3, 64'h10);
        chk("R10", "timer_irq below threshold", {63'd0, timer_irq}, 64'd0);

        // R10 long retire run reaches the threshold
        cur_tag = "R10";
        retire = 1'b1;
        repeat (60) @(negedge clk);
        retire = 1'b0;
        rd_expect("R2", 16'hBFF8, 2'd3, 64'd22);
        chk("R10", "timer_irq at or above threshold", {63'd0, timer_irq}, 64'd1);
        access(1'b0, 1'b1, 16'h4000, 2'd3, 64'h8000_0000_0000_0000, 1'b0);
        chk("R10", "unsigned compare", {63'd0, timer_irq}, 64'd0);
        access(1'b0, 1'b1, 16'h4000, 2'd2, 64'd22, 1'b0);
        access(1'b0, 1'b1, 16'h4004, 2'd2, 64'd0, 1'b0);
        chk("R10", "equal counts", {63'd0, timer_irq}, 64'd1);
        access(1'b0, 1'b1, 16'h4000, 2'd3, 64'h8000_0000_0000_0000, 1'b0);

        // R7 software flag
        cur_tag = "R7";
        access(1'b0, 1'b1, 16'h0000, 2'd3, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0);
        chk("R7", "sw_irq set", {63'd0, sw_irq}, 64'd1);
        rd_expect("R7", 16'h0000, 2'd3, 64'd1);
        access(1'b0, 1'b1, 16'h0000, 2'd2, 64'd2, 1'b0);
        chk("R7", "sw_irq cleared", {63'd0, sw_irq}, 64'd0);

        // R5 rejected accesses
        cur_tag = "R5";
        access(1'b0, 1'b1, 16'h0000, 2'd0, '1, 1'b0);
        chk("R5", "err size 1", {63'd0, acc_err}, 64'd1);
        access(1'b0, 1'b1, 16'h0000, 2'd1, '1, 1'b0);
        chk("R5", "err size 2 bytes", {63'd0, acc_err}, 64'd1);
        access(1'b0, 1'b1, 16'h0004, 2'd2, '1, 1'b0);
        access(1'b0, 1'b1, 16'h4004, 2'd3, '1, 1'b0);
        chk("R5", "err high half 8 byte", {63'd0, acc_err}, 64'd1);
        access(1'b0, 1'b1, 16'hBFFC, 2'd3, '1, 1'b0);
        access(1'b0, 1'b1, 16'h2000, 2'd2, '1, 1'b0);
        access(1'b0, 1'b1, 16'h4002, 2'd2, '1, 1'b0);
        access(1'b1, 1'b0, 16'hBFF9, 2'd2, '0, 1'b0);
        chk("R5", "err misaligned read data", acc_rdata, 64'd0);
        access(1'b1, 1'b1, 16'h4000, 2'd3, '1, 1'b0);
        chk("R5", "err rd and wr", {63'd0, acc_err}, 64'd1);
        rd_expect("R5", 16'h4000, 2'd3, 64'h8000_0000_0000_0000);
        rd_expect("R5", 16'h0000, 2'd3, 64'd0);
        rd_expect("R5", 16'hBFF8, 2'd3, 64'd22);

        // R9 time writes, carry and tick collision
        cur_tag = "R9";
        access(1'b0, 1'b1, 16'hBFF8, 2'd3, 64'h0000_0000_FFFF_FFFE, 1'b0);
        retire = 1'b1;
        repeat (2 * N) @(negedge clk);
        retire = 1'b0;
        rd_expect("R2", 16'hBFFC, 2'd2, 64'd1);
        rd_expect("R9", 16'hBFF8, 2'd2, 64'd0);
        for (int k = 0; k < N; k++) access(1'b0, 1'b1, 16'hBFF8, 2'd2, 64'd5, 1'b1);
        rd_expect("R9", 16'hBFF8, 2'd3, 64'h1_0000_0005);
        access(1'b0, 1'b1, 16'hBFFC, 2'd2, 64'h7, 1'b0);
        rd_expect("R9", 16'hBFF8, 2'd3, 64'h7_0000_0005);

        // R4 mixed traffic, compared on every clock against the model
        cur_tag = "R4";
        access(1'b0, 1'b1, 16'hBFF8, 2'd3, 64'd0, 1'b0);
        access(1'b0, 1'b1, 16'h4000, 2'd3, 64'd40, 1'b0);
        for (int i = 0; i < 300; i++) begin
            logic ret;
            ret = ((i % 5) != 2);
            case (i % 12)
                0:  access(1'b1, 1'b0, 16'hBFF8, 2'd3, 64'd0, ret);
                1:  access(1'b1, 1'b0, 16'hBFFC, 2'd2, 64'd0, ret);
                2:  access(1'b0, 1'b1, 16'h4000, 2'd2, 64'(i / 4), ret);
                3:  access(1'b1, 1'b0, 16'h4000, 2'd3, 64'd0, ret);
                4:  access(1'b0, 1'b1, 16'h0000, 2'd2, 64'(i), ret);
                5:  access(1'b1, 1'b0, 16'h0000, 2'd3, 64'd0, ret);
                6:  access(1'b0, 1'b1, 16'h4008, 2'd2, 64'(i), ret);
                7:  access(1'b1, 1'b0, 16'h4004, 2'd2, 64'd0, ret);
                8:  access(1'b0, 1'b1, 16'hBFF8, 2'd2, 64'(i / 3), ret);
                9:  access(1'b1, 1'b0, 16'hBFF8, 2'd1, 64'd0, ret);
                10: access(1'b0, 1'b0, 16'h0000, 2'd0, 64'd0, ret);
                default: access(1'b1, 1'b0, 16'hBFF8, 2'd2, 64'd0, ret);
            endcase
        end

        repeat (3) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule